// File: doc/BRIEF.md
# Nibble-Register Program Sequencer

This block steers the program counter of a 4-bit processor whose program addresses are 12 bits wide. Software sees the counter as three 4-bit registers. The high and middle parts are staging registers that only hold a value. The low part and a separate call register act on the flow of execution. A write to either of these two registers starts a jump or a subroutine call to the address formed by the staged high and middle nibbles and the written nibble. It does so only when the instruction decoder marks the write as one that may trigger.

Return addresses are kept on a five-entry stack. Each entry is stored as three nibbles, and the stack pointer names the next free entry. A return hands its 4-bit immediate to register R0 in the same cycle, pops the stack and resumes at the popped address. The block also provides plain sequential stepping and a PC-relative branch with an 8-bit signed offset.

One instruction is executed in each cycle in which `step_i` is high.

Top module: `pc_seq`

## Requirements
- R1: After reset `pc_o` is 0, `sp_o` is 0 and `stk_err_o` is 0.
- R2: A step with no control request sets `pc_o` to `pc_o`+1 modulo 4096. With `step_i` low, `pc_o` and `sp_o` hold, whatever the other inputs are.
- R3: A write selecting the high (`wr_sel_i`=0) or middle (`wr_sel_i`=1) nibble stores `wr_data_i` in that staging nibble. `ld_stage_i` stores `ld_stage_data_i[7:4]` as the high nibble and `[3:0]` as the middle nibble. Neither of these changes flow: the PC advances by one, whatever `wr_trig_i` is.
- R4: A write to the low nibble (`wr_sel_i`=2) with `wr_trig_i`=1 sets `pc_o` to {high, middle, `wr_data_i`}.
- R5: A write to the call register (`wr_sel_i`=3) with `wr_trig_i`=1 pushes `pc_o`+1, increments `sp_o` and sets `pc_o` to {high, middle, `wr_data_i`}.
- R6: A write to the low nibble or to the call register with `wr_trig_i`=0 does not change flow: `pc_o` advances by one and `sp_o` is unchanged.
- R7: A return (`ret_i`) raises `r0_wr_o` with `r0_data_o`=`ret_imm_i` in the same cycle. It then decrements `sp_o` and loads `pc_o` from the entry at the new `sp_o`.
- R8: Calls and returns nest in last-in first-out order to a depth of 5.
- R9: A branch (`br_i`) sets `pc_o` to `pc_o`+1+sign-extended `br_off_i`, modulo 4096.
- R10: A call at `sp_o`=5 or a return at `sp_o`=0 sets `stk_err_o`. In that case `sp_o` is unchanged and `pc_o` advances by one. `stk_err_o` stays set until reset.
- R11: When several requests share a step, a return takes precedence over a branch, and a branch takes precedence over a nibble write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | One instruction executes this cycle |
| wr_en_i | input | 1 | Nibble write to a sequencer register |
| wr_sel_i | input | 2 | Target: 0 high, 1 middle, 2 low, 3 call |
| wr_data_i | input | 4 | Nibble written |
| wr_trig_i | input | 1 | The write may start a jump or call |
| ld_stage_i | input | 1 | Immediate load of high and middle nibbles |
| ld_stage_data_i | input | 8 | {high, middle} for the immediate load |
| ret_i | input | 1 | Return request |
| ret_imm_i | input | 4 | Immediate operand of the return |
| br_i | input | 1 | Relative branch request |
| br_off_i | input | 8 | Signed branch offset |
| pc_o | output | 12 | Program counter |
| sp_o | output | 3 | Stack pointer (next free entry) |
| stk_err_o | output | 1 | Sticky stack overflow or underflow |
| r0_wr_o | output | 1 | Write strobe for R0 |
| r0_data_o | output | 4 | Data for R0 |

## Verification
`pc_o`, `sp_o` and `stk_err_o` are registered. Each takes its new value at the first rising edge after the step that causes it. `r0_wr_o` and `r0_data_o` follow a return request combinationally, within the same cycle. The bench changes inputs on the falling edge. It samples the R0 strobe shortly after driving and before the rising edge, and it samples the registered outputs at the following falling edge. The expected value for every step is therefore exactly one edge old.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [1:0] {SEL_HI = 2'd0, SEL_MID = 2'd1, SEL_LO = 2'd2, SEL_CALL = 2'd3} pc_sel_e;
  typedef enum logic [2:0] {NX_HOLD, NX_SEQ, NX_JUMP, NX_BRANCH, NX_RET} nxt_kind_e;
endpackage

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int NIB_W = 4,
  parameter int NIBS  = 3,
  parameter int DEPTH = 5,
  localparam int AW    = NIB_W * NIBS,
  localparam int SPW   = $clog2(DEPTH + 1),
  localparam int SLOTS = DEPTH * NIBS,
  localparam int IDXW  = $clog2(SLOTS + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic           pop_i,
  input  logic [AW-1:0]  push_addr_i,
  output logic [AW-1:0]  pop_addr_o,
  output logic [SPW-1:0] sp_o,
  output logic           full_o,
  output logic           empty_o
);
  logic [SPW-1:0]   sp_q;
  logic [NIB_W-1:0] mem [SLOTS];
  logic [IDXW-1:0]  wr_base, rd_base;
  logic [SPW-1:0]   rd_sp;

  assign full_o  = (sp_q == SPW'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign rd_sp   = empty_o ? '0 : sp_q - 1'b1;
  assign wr_base = IDXW'(sp_q) * IDXW'(NIBS);
  assign rd_base = IDXW'(rd_sp) * IDXW'(NIBS);
  assign sp_o    = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sp_q <= '0;
    else if (push_i && !full_o) sp_q <= sp_q + 1'b1;
    else if (pop_i && !empty_o) sp_q <= sp_q - 1'b1;
  end

  // entry slot k holds nibble k, low nibble at the lowest slot
  for (genvar k = 0; k < NIBS; k++) begin : g_nib
    always_ff @(posedge clk_i) begin
      if (push_i && !full_o) mem[wr_base + IDXW'(k)] <= push_addr_i[k*NIB_W +: NIB_W];
    end
    assign pop_addr_o[k*NIB_W +: NIB_W] = mem[rd_base + IDXW'(k)];
  end

  a_r10_sp_bound: assert property (@(posedge clk_i) disable iff (!rst_ni) sp_q <= SPW'(DEPTH));
  a_r5_push_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o) |=> sp_q == SPW'($past(sp_q) + 1'b1));
  a_r7_pop_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty_o) |=> sp_q == SPW'($past(sp_q) - 1'b1));
endmodule

// File: rtl/pc_next.sv
module pc_next
  import pc_seq_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int NIBS  = 3,
  parameter int OFF_W = 8,
  localparam int AW   = NIB_W * NIBS
) (
  input  nxt_kind_e             kind_i,
  input  logic [AW-1:0]         pc_i,
  input  logic [AW-NIB_W-1:0]   stage_i,
  input  logic [NIB_W-1:0]      low_i,
  input  logic [OFF_W-1:0]      off_i,
  input  logic [AW-1:0]         ret_addr_i,
  output logic [AW-1:0]         pc_inc_o,
  output logic [AW-1:0]         nxt_o
);
  logic [AW-1:0] off_ext;
  assign off_ext  = {{(AW-OFF_W){off_i[OFF_W-1]}}, off_i};
  assign pc_inc_o = pc_i + 1'b1;

  always_comb begin
    case (kind_i)
      NX_SEQ:    nxt_o = pc_inc_o;
      NX_JUMP:   nxt_o = {stage_i, low_i};
      NX_BRANCH: nxt_o = pc_inc_o + off_ext;
      NX_RET:    nxt_o = ret_addr_i;
      default:   nxt_o = pc_i;
    endcase
  end
endmodule

// File: rtl/pc_seq.sv
module pc_seq
  import pc_seq_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int NIBS  = 3,
  parameter int DEPTH = 5,
  parameter int OFF_W = 8,
  localparam int AW   = NIB_W * NIBS,
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int STW  = AW - NIB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [NIB_W-1:0] wr_data_i,
  input  logic             wr_trig_i,
  input  logic             ld_stage_i,
  input  logic [STW-1:0]   ld_stage_data_i,
  input  logic             ret_i,
  input  logic [NIB_W-1:0] ret_imm_i,
  input  logic             br_i,
  input  logic [OFF_W-1:0] br_off_i,
  output logic [AW-1:0]    pc_o,
  output logic [SPW-1:0]   sp_o,
  output logic             stk_err_o,
  output logic             r0_wr_o,
  output logic [NIB_W-1:0] r0_data_o
);
  logic [AW-1:0]    pc_q, pc_d, pc_inc, ret_addr;
  logic [NIB_W-1:0] hi_q, mid_q;
  logic             err_q, full, empty;
  logic             do_ret, do_br, wr_act, jmp_lo, call_req, call_ok, ret_ok, err_set;
  pc_sel_e          sel;
  nxt_kind_e        kind;

  assign sel      = pc_sel_e'(wr_sel_i);
  assign do_ret   = step_i && ret_i;
  assign do_br    = step_i && br_i && !ret_i;
  assign wr_act   = step_i && wr_en_i && !ret_i && !br_i;
  assign jmp_lo   = wr_act && wr_trig_i && (sel == SEL_LO);
  assign call_req = wr_act && wr_trig_i && (sel == SEL_CALL);
  assign call_ok  = call_req && !full;
  assign ret_ok   = do_ret && !empty;
  assign err_set  = (call_req && full) || (do_ret && empty);

  always_comb begin
    if (!step_i)              kind = NX_HOLD;
    else if (ret_ok)          kind = NX_RET;
    else if (do_br)           kind = NX_BRANCH;
    else if (jmp_lo || call_ok) kind = NX_JUMP;
    else                      kind = NX_SEQ;
  end

  pc_next #(.NIB_W(NIB_W), .NIBS(NIBS), .OFF_W(OFF_W)) u_next (
    .kind_i    (kind),
    .pc_i      (pc_q),
    .stage_i   ({hi_q, mid_q}),
    .low_i     (wr_data_i),
    .off_i     (br_off_i),
    .ret_addr_i(ret_addr),
    .pc_inc_o  (pc_inc),
    .nxt_o     (pc_d)
  );

  ret_stack #(.NIB_W(NIB_W), .NIBS(NIBS), .DEPTH(DEPTH)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (call_ok),
    .pop_i      (ret_ok),
    .push_addr_i(pc_inc),
    .pop_addr_o (ret_addr),
    .sp_o       (sp_o),
    .full_o     (full),
    .empty_o    (empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      hi_q  <= '0;
      mid_q <= '0;
      err_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      err_q <= err_q | err_set;
      if (step_i && ld_stage_i) {hi_q, mid_q} <= ld_stage_data_i;
      else if (wr_act && sel == SEL_HI)  hi_q  <= wr_data_i;
      else if (wr_act && sel == SEL_MID) mid_q <= wr_data_i;
    end
  end

  assign pc_o      = pc_q;
  assign stk_err_o = err_q;
  assign r0_wr_o   = do_ret;
  assign r0_data_o = ret_imm_i;

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> (pc_q == $past(pc_q)) && (sp_o == $past(sp_o)));
  a_r6_plain_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && wr_en_i && !wr_trig_i && !ret_i && !br_i) |=>
      (pc_q == AW'($past(pc_q) + 1'b1)) && (sp_o == $past(sp_o)));
  a_r3_stage_no_flow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ret_i && !br_i && (!wr_en_i || wr_sel_i[1] == 1'b0)) |=>
      pc_q == AW'($past(pc_q) + 1'b1));
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_err_o |=> stk_err_o);
endmodule

// File: tb/sim_pc_seq.sv
module sim_pc_seq;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       step_i = 0, wr_en_i = 0, wr_trig_i = 0, ld_stage_i = 0, ret_i = 0, br_i = 0;
  logic [1:0] wr_sel_i = 0;
  logic [3:0] wr_data_i = 0, ret_imm_i = 0;
  logic [7:0] ld_stage_data_i = 0, br_off_i = 0;
  logic [11:0] pc_o;
  logic [2:0]  sp_o;
  logic        stk_err_o, r0_wr_o;
  logic [3:0]  r0_data_o;
  logic        r0_seen;
  logic [3:0]  r0_val;
  int n_vec = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  pc_seq u0 (.*);

  // op codes: 0 nop, 1 wr high, 2 wr mid, 3 wr low, 4 wr call, 5 ret, 6 branch, 7 stage load
  // vector = {op[3], trig[1], data[8], exp_pc[12], exp_sp[3]}
  localparam logic [26:0] VEC [17] = '{
    {3'd0, 1'b0, 8'h00, 12'h001, 3'd0},  // R2
    {3'd7, 1'b0, 8'h12, 12'h002, 3'd0},  // R3
    {3'd3, 1'b1, 8'h05, 12'h125, 3'd0},  // R4
    {3'd3, 1'b0, 8'h09, 12'h126, 3'd0},  // R6
    {3'd4, 1'b1, 8'h0A, 12'h12A, 3'd1},  // R5
    {3'd1, 1'b1, 8'h03, 12'h12B, 3'd1},  // R3
    {3'd2, 1'b0, 8'h04, 12'h12C, 3'd1},  // R3
    {3'd4, 1'b1, 8'h07, 12'h347, 3'd2},  // R5
    {3'd6, 1'b0, 8'hFE, 12'h346, 3'd2},  // R9
    {3'd6, 1'b0, 8'h10, 12'h357, 3'd2},  // R9
    {3'd5, 1'b0, 8'h06, 12'h12D, 3'd1},  // R7
    {3'd5, 1'b0, 8'h00, 12'h127, 3'd0},  // R7
    {3'd7, 1'b0, 8'hFF, 12'h128, 3'd0},  // R3
    {3'd3, 1'b1, 8'h0F, 12'hFFF, 3'd0},  // R4
    {3'd0, 1'b0, 8'h00, 12'h000, 3'd0},  // R2 wrap
    {3'd6, 1'b0, 8'h80, 12'hF81, 3'd0},  // R9
    {3'd4, 1'b0, 8'h01, 12'hF82, 3'd0}   // R6
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic trig, input logic [7:0] d);
    step_i = 1'b1; wr_trig_i = trig;
    wr_en_i = (op >= 3'd1 && op <= 3'd4);
    wr_sel_i = 2'(op - 3'd1);
    wr_data_i = d[3:0];
    ret_i = (op == 3'd5); ret_imm_i = d[3:0];
    br_i = (op == 3'd6); br_off_i = d;
    ld_stage_i = (op == 3'd7); ld_stage_data_i = d;
    #1; r0_seen = r0_wr_o; r0_val = r0_data_o;
    @(posedge clk_i); @(negedge clk_i);
    step_i = 0; wr_en_i = 0; wr_trig_i = 0; ret_i = 0; br_i = 0; ld_stage_i = 0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; @(negedge clk_i); @(negedge clk_i); rst_ni = 1'b1; @(negedge clk_i);
  endtask

  initial begin
    logic [11:0] epc;
    do_reset();
    check("R1 pc", 16'(pc_o), 16'h0);
    check("R1 sp", 16'(sp_o), 16'h0);
    check("R1 err", 16'(stk_err_o), 16'h0);

    for (int i = 0; i < 17; i++) begin
      drive(VEC[i][26:24], VEC[i][23], VEC[i][22:15]);
      check("table pc", 16'(pc_o), 16'(VEC[i][14:3]));
      check("table sp", 16'(sp_o), 16'(VEC[i][2:0]));
      if (VEC[i][26:24] == 3'd5) begin
        check("R7 r0 strobe", 16'(r0_seen), 16'h1);
        check("R7 r0 data", 16'(r0_val), 16'(VEC[i][18:15]));
      end
    end

    // R2: no step, nothing moves even with requests present
    epc = pc_o;
    wr_en_i = 1; wr_sel_i = 2'd3; wr_trig_i = 1; br_i = 1; br_off_i = 8'h20;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 0; wr_trig_i = 0; br_i = 0;
    check("R2 hold pc", 16'(pc_o), 16'(epc));
    check("R2 hold sp", 16'(sp_o), 16'h0);

    // R8/R10: nest to depth 5, overflow, unwind, underflow
    do_reset();
    drive(3'd7, 1'b0, 8'h40);
    for (int k = 0; k < 5; k++) begin
      drive(3'd4, 1'b1, 8'(k));
      check("R8 call pc", 16'(pc_o), 16'(12'h400 + k));
      check("R8 call sp", 16'(sp_o), 16'(k + 1));
    end
    check("R10 no err yet", 16'(stk_err_o), 16'h0);
    drive(3'd4, 1'b1, 8'h09);
    check("R10 ovf err", 16'(stk_err_o), 16'h1);
    check("R10 ovf sp", 16'(sp_o), 16'h5);
    check("R10 ovf pc", 16'(pc_o), 16'h405);
    for (int k = 0; k < 5; k++) begin
      drive(3'd5, 1'b0, 8'h0);
      epc = (k == 4) ? 12'h002 : 12'(12'h404 - k);
      check("R8 ret pc", 16'(pc_o), 16'(epc));
      check("R8 ret sp", 16'(sp_o), 16'(4 - k));
    end
    check("R10 err sticky", 16'(stk_err_o), 16'h1);

    do_reset();
    check("R1 err cleared", 16'(stk_err_o), 16'h0);
    drive(3'd5, 1'b0, 8'h0B);
    check("R10 udf err", 16'(stk_err_o), 16'h1);
    check("R10 udf sp", 16'(sp_o), 16'h0);
    check("R10 udf pc", 16'(pc_o), 16'h001);
    check("R7 udf r0", 16'(r0_val), 16'h00B);

    // R11: branch beats triggered low write; return beats branch
    step_i = 1; br_i = 1; br_off_i = 8'h04; wr_en_i = 1; wr_sel_i = 2'd2; wr_trig_i = 1; wr_data_i = 4'h7;
    @(posedge clk_i); @(negedge clk_i);
    step_i = 0; br_i = 0; wr_en_i = 0; wr_trig_i = 0;
    check("R11 br over wr", 16'(pc_o), 16'h006);
    drive(3'd4, 1'b1, 8'h0C);  // call 0x00C, pushes 0x007
    step_i = 1; ret_i = 1; ret_imm_i = 4'h1; br_i = 1; br_off_i = 8'h40;
    @(posedge clk_i); @(negedge clk_i);
    step_i = 0; ret_i = 0; br_i = 0;
    check("R11 ret over br", 16'(pc_o), 16'h007);
    check("R11 ret sp", 16'(sp_o), 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule